// File: doc/BRIEF.md
# Memory Dependency Group Tracker

This block holds a fixed table of memory dependency groups for an out-of-order scheduler model. A group collects memory operations that carry no ordering constraint among themselves. Directed edges from one group to later groups express ordering. For every group the block keeps counters for its own members and for its predecessor groups. From those counters it reports, per group, whether the group may start, may start soon, or must keep waiting.

A single event port carries one event per cycle. The event can add a member to a group, link two groups, mark a member issued with its remaining latency, or mark a member finished. When a group starts or completes, all of its successors are updated in the same cycle. A separate tick input ages latency estimates. A query port returns the longest-latency predecessor known to a selected group. A sticky error output flags any event that breaks the table's rules. Index 0 of the table is reserved and never holds a group.

Top module: `mdg_tracker`

## Requirements
- R1: After reset every group 1..N-1 reports ready and executed and none reports waiting, pending or executing. Bit 0 of every status vector is always 0. `err` is 0, and the query port returns latency 0 and id 0.
- R2: With P predecessors, of which E are executing and D have executed, a group reports waiting when P > E+D. It reports pending when E > 0 and E+D = P. It reports ready when D = P. Exactly one of the three holds for each group 1..N-1.
- R3: With M members, of which X are executing and F have finished, a group reports executing when X > 0 and X = M-F. It reports executed when F = M. The two never hold together.
- R4: Event codes are 0 add member, 1 add edge `ev_src`->`ev_dst`, 2 member issued, 3 member finished. The group a member or issue event addresses is `ev_src`. An issue records (`ev_iid`, `ev_lat`) as the group's critical member when the group has none yet, or when `ev_lat` is strictly larger than the critical member's remaining latency. That remaining latency drops by one on each tick while it is nonzero.
- R5: The issue that makes a group executing increments the executing-predecessor count of every successor. Each successor adopts the group's critical member (id, latency) when that latency exceeds the latency it already holds.
- R6: The finish event that makes a group executed moves one predecessor from executing to executed in every successor, in the same cycle.
- R7: A legal edge increments the destination's predecessor count. If the source is executing at that moment, the destination also counts it as an executing predecessor and is offered the source's current critical member.
- R8: On a tick, a waiting group whose critical-predecessor latency is nonzero lowers it by one. A pending or ready group keeps its latency, and a latency of 0 stays 0.
- R9: These events are illegal: any event addressing group 0; an edge to 0, to itself, one that already exists, or one from an executed group; adding a member to a group that has a successor or whose member count is at its maximum; an issue with no unissued member; a finish on a group that is not ready or has no executing member. An illegal event changes no state and sets `err`, which stays set until reset.
- R10: `q_crit_iid`/`q_crit_lat` combinationally show the critical predecessor of group `q_grp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 2 | Event code (see R4) |
| ev_src | input | IXW | Addressed group, or edge source |
| ev_dst | input | IXW | Edge destination |
| ev_iid | input | IW | Issuing member id |
| ev_lat | input | LW | Issuing member remaining latency |
| tick | input | 1 | Cycle tick for latency ageing |
| q_grp | input | IXW | Group selected for the query |
| st_waiting | output | N | Per-group waiting flag |
| st_pending | output | N | Per-group pending flag |
| st_ready | output | N | Per-group ready flag |
| st_executing | output | N | Per-group executing flag |
| st_executed | output | N | Per-group executed flag |
| q_crit_iid | output | IW | Critical predecessor id of `q_grp` |
| q_crit_lat | output | LW | Critical predecessor latency of `q_grp` |
| err | output | 1 | Sticky illegal-event flag |

## Verification
The bench builds the tracker with 8 groups, 3-bit counters, 4-bit latencies and 6-bit ids. The 3-bit member counter saturates after seven additions, so the overflow rejection is reached with a short stimulus. The 4-bit latency keeps the tick countdown, including its stop at zero, within a few cycles. Seven usable groups are still enough for two-predecessor joins, live edges from executing groups and all the rejected edge shapes.

// File: rtl/mdg_pkg.sv
package mdg_pkg;

   typedef enum logic [1:0] {
      EV_ADD_INST = 2'd0,
      EV_ADD_EDGE = 2'd1,
      EV_ISSUE    = 2'd2,
      EV_EXEC     = 2'd3
   } mdg_ev_e;

endpackage

// File: rtl/mdg_group_slot.sv
module mdg_group_slot #(
   parameter int N            = 16,
   parameter int CW           = 4,
   parameter int LW           = 8,
   parameter int IW           = 8,
   parameter bit MEMBER_DECAY = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          inst_add,
   input  logic          mem_issue,
   input  logic          mem_done,
   input  logic          pred_add,
   input  logic          pred_issue,
   input  logic          pred_done,
   input  logic [N-1:1]  succ_set,
   input  logic [IW-1:0] in_iid,
   input  logic [LW-1:0] in_lat,
   input  logic [IW-1:0] nfy_iid,
   input  logic [LW-1:0] nfy_lat,
   output logic          st_waiting,
   output logic          st_pending,
   output logic          st_ready,
   output logic          st_executing,
   output logic          st_executed,
   output logic [N-1:1]  succ_row,
   output logic          inst_full,
   output logic          has_succ,
   output logic          unissued,
   output logic          exec_ok,
   output logic          issue_starts,
   output logic          exec_finishes,
   output logic [IW-1:0] cand_iid,
   output logic [LW-1:0] cand_lat,
   output logic [IW-1:0] cur_iid,
   output logic [LW-1:0] cur_lat,
   output logic [IW-1:0] pred_iid,
   output logic [LW-1:0] pred_lat
);

   localparam int SW = CW + 1;

   logic [CW-1:0] ninst, nexing, nexed;
   logic [CW-1:0] npred, pexing, pexed;
   logic [N-1:1]  succ;
   logic          mem_has;
   logic [SW-1:0] mem_busy, pred_seen, left_cnt;
   logic          take_new;

   // derived counts, one extra bit so sums never wrap
   assign mem_busy  = {1'b0, nexing} + {1'b0, nexed};
   assign pred_seen = {1'b0, pexing} + {1'b0, pexed};
   assign left_cnt  = {1'b0, ninst} - {1'b0, nexed};

   assign st_waiting   = {1'b0, npred} > pred_seen;
   assign st_pending   = (pexing != '0) && (pred_seen == {1'b0, npred});
   assign st_ready     = (pexed == npred);
   assign st_executing = (nexing != '0) && ({1'b0, nexing} == left_cnt);
   assign st_executed  = (ninst == nexed);

   assign succ_row      = succ;
   assign has_succ      = |succ;
   assign inst_full     = &ninst;
   assign unissued      = mem_busy < {1'b0, ninst};
   assign exec_ok       = st_ready && (nexing != '0);
   assign issue_starts  = ({1'b0, nexing} + SW'(1)) == left_cnt;
   assign exec_finishes = ({1'b0, nexed} + SW'(1)) == {1'b0, ninst};

   // candidate critical member if an issue with (in_iid, in_lat) lands now
   assign take_new = !mem_has || (cur_lat < in_lat);
   assign cand_iid = take_new ? in_iid : cur_iid;
   assign cand_lat = take_new ? in_lat : cur_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ninst    <= '0;
         nexing   <= '0;
         nexed    <= '0;
         npred    <= '0;
         pexing   <= '0;
         pexed    <= '0;
         succ     <= '0;
         pred_iid <= '0;
         pred_lat <= '0;
      end else begin
         if (inst_add) ninst <= ninst + CW'(1);
         succ <= succ | succ_set;

         if (mem_issue)     nexing <= nexing + CW'(1);
         else if (mem_done) nexing <= nexing - CW'(1);
         if (mem_done)      nexed  <= nexed + CW'(1);

         if (pred_add)       npred  <= npred + CW'(1);
         if (pred_issue)     pexing <= pexing + CW'(1);
         else if (pred_done) pexing <= pexing - CW'(1);
         if (pred_done)      pexed  <= pexed + CW'(1);

         if (pred_issue) begin
            if (pred_lat < nfy_lat) begin
               pred_iid <= nfy_iid;
               pred_lat <= nfy_lat;
            end
         end else if (tick && st_waiting && (pred_lat != '0)) begin
            pred_lat <= pred_lat - LW'(1);
         end
      end
   end

   // critical member: either ages with the tick or keeps its issue-time value
   if (MEMBER_DECAY) begin : g_decay
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_has <= 1'b0;
            cur_iid <= '0;
            cur_lat <= '0;
         end else if (mem_issue) begin
            mem_has <= 1'b1;
            cur_iid <= cand_iid;
            cur_lat <= cand_lat;
         end else if (tick && (cur_lat != '0)) begin
            cur_lat <= cur_lat - LW'(1);
         end
      end
   end else begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mem_has <= 1'b0;
            cur_iid <= '0;
            cur_lat <= '0;
         end else if (mem_issue) begin
            mem_has <= 1'b1;
            cur_iid <= cand_iid;
            cur_lat <= cand_lat;
         end
      end
   end

endmodule

// File: rtl/mdg_event_ctrl.sv
module mdg_event_ctrl
   import mdg_pkg::*;
#(
   parameter int N   = 16,
   parameter int IXW = 4
) (
   input  logic                  ev_valid,
   input  mdg_ev_e               ev_kind,
   input  logic [IXW-1:0]        ev_src,
   input  logic [IXW-1:0]        ev_dst,
   input  logic [N-1:1]          inst_full,
   input  logic [N-1:1]          has_succ,
   input  logic [N-1:1]          unissued,
   input  logic [N-1:1]          exec_ok,
   input  logic [N-1:1]          executing,
   input  logic [N-1:1]          executed,
   input  logic [N-1:1]          issue_starts,
   input  logic [N-1:1]          exec_finishes,
   input  logic [N-1:1][N-1:1]   succ_rows,
   output logic                  illegal,
   output logic [N-1:1]          inst_add_v,
   output logic [N-1:1]          mem_issue_v,
   output logic [N-1:1]          mem_done_v,
   output logic [N-1:1]          pred_add_v,
   output logic [N-1:1]          pred_issue_v,
   output logic [N-1:1]          pred_done_v,
   output logic [N-1:1][N-1:1]   succ_set_m,
   output logic                  use_cur
);

   logic [N-1:1] src_oh, dst_oh, src_row;
   logic         src_ok, dst_ok, dup_edge, legal, go;

   for (genvar g = 1; g < N; g++) begin : g_oh
      assign src_oh[g] = (ev_src == IXW'(g));
      assign dst_oh[g] = (ev_dst == IXW'(g));
   end

   assign src_ok = (ev_src != '0);
   assign dst_ok = (ev_dst != '0);

   always_comb begin
      src_row = '0;
      for (int g = 1; g < N; g++) begin
         if (src_oh[g]) src_row = src_row | succ_rows[g];
      end
   end

   assign dup_edge = |(src_row & dst_oh);

   always_comb begin
      unique case (ev_kind)
         EV_ADD_INST: legal = src_ok && !(|(src_oh & has_succ)) && !(|(src_oh & inst_full));
         EV_ADD_EDGE: legal = src_ok && dst_ok && (ev_src != ev_dst) && !(|(src_oh & executed)) && !dup_edge;
         EV_ISSUE:    legal = src_ok && (|(src_oh & unissued));
         EV_EXEC:     legal = src_ok && (|(src_oh & exec_ok));
         default:     legal = 1'b0;
      endcase
   end

   assign illegal = ev_valid && !legal;
   assign go      = ev_valid && legal;
   assign use_cur = (ev_kind == EV_ADD_EDGE);

   always_comb begin
      inst_add_v   = '0;
      mem_issue_v  = '0;
      mem_done_v   = '0;
      pred_add_v   = '0;
      pred_issue_v = '0;
      pred_done_v  = '0;
      if (go) begin
         unique case (ev_kind)
            EV_ADD_INST: inst_add_v = src_oh;
            EV_ADD_EDGE: begin
               pred_add_v = dst_oh;
               if (|(src_oh & executing)) pred_issue_v = dst_oh;
            end
            EV_ISSUE: begin
               mem_issue_v = src_oh;
               if (|(src_oh & issue_starts)) pred_issue_v = src_row;
            end
            EV_EXEC: begin
               mem_done_v = src_oh;
               if (|(src_oh & exec_finishes)) pred_done_v = src_row;
            end
            default: ;
         endcase
      end
   end

   for (genvar g = 1; g < N; g++) begin : g_set
      assign succ_set_m[g] = (go && (ev_kind == EV_ADD_EDGE) && src_oh[g]) ? dst_oh : '0;
   end

endmodule

// File: rtl/mdg_tracker.sv
module mdg_tracker
   import mdg_pkg::*;
#(
   parameter int N            = 16,
   parameter int CW           = 4,
   parameter int LW           = 8,
   parameter int IW           = 8,
   parameter bit MEMBER_DECAY = 1'b1,
   localparam int IXW         = $clog2(N)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ev_valid,
   input  logic [1:0]     ev_kind,
   input  logic [IXW-1:0] ev_src,
   input  logic [IXW-1:0] ev_dst,
   input  logic [IW-1:0]  ev_iid,
   input  logic [LW-1:0]  ev_lat,
   input  logic           tick,
   input  logic [IXW-1:0] q_grp,
   output logic [N-1:0]   st_waiting,
   output logic [N-1:0]   st_pending,
   output logic [N-1:0]   st_ready,
   output logic [N-1:0]   st_executing,
   output logic [N-1:0]   st_executed,
   output logic [IW-1:0]  q_crit_iid,
   output logic [LW-1:0]  q_crit_lat,
   output logic           err
);

   if (N < 3) begin : g_bad_n
      $error("mdg_tracker: N must be at least 3");
   end
   if (CW < IXW) begin : g_bad_cw
      $error("mdg_tracker: CW too narrow to count every predecessor");
   end
   if ((LW < 1) || (IW < 1)) begin : g_bad_w
      $error("mdg_tracker: LW and IW must be positive");
   end

   mdg_ev_e kind_e;
   assign kind_e = mdg_ev_e'(ev_kind);

   logic [N-1:1]          w_a, p_a, r_a, x_a, d_a;
   logic [N-1:1]          full_a, hsucc_a, unis_a, xok_a, starts_a, fin_a;
   logic [N-1:1][N-1:1]   rows_a, set_m;
   logic [N-1:1]          inst_add_v, mem_issue_v, mem_done_v;
   logic [N-1:1]          pred_add_v, pred_issue_v, pred_done_v;
   logic [IW-1:0]         cand_iid_a [N-1:1];
   logic [LW-1:0]         cand_lat_a [N-1:1];
   logic [IW-1:0]         cur_iid_a  [N-1:1];
   logic [LW-1:0]         cur_lat_a  [N-1:1];
   logic [IW-1:0]         pred_iid_a [N-1:1];
   logic [LW-1:0]         pred_lat_a [N-1:1];
   logic                  illegal, use_cur;
   logic [IW-1:0]         nfy_iid;
   logic [LW-1:0]         nfy_lat;

   mdg_event_ctrl #(.N(N), .IXW(IXW)) u_ctrl (
      .ev_valid      (ev_valid),
      .ev_kind       (kind_e),
      .ev_src        (ev_src),
      .ev_dst        (ev_dst),
      .inst_full     (full_a),
      .has_succ      (hsucc_a),
      .unissued      (unis_a),
      .exec_ok       (xok_a),
      .executing     (x_a),
      .executed      (d_a),
      .issue_starts  (starts_a),
      .exec_finishes (fin_a),
      .succ_rows     (rows_a),
      .illegal       (illegal),
      .inst_add_v    (inst_add_v),
      .mem_issue_v   (mem_issue_v),
      .mem_done_v    (mem_done_v),
      .pred_add_v    (pred_add_v),
      .pred_issue_v  (pred_issue_v),
      .pred_done_v   (pred_done_v),
      .succ_set_m    (set_m),
      .use_cur       (use_cur)
   );

   // critical member of the source group, offered to its successors
   always_comb begin
      nfy_iid = '0;
      nfy_lat = '0;
      for (int g = 1; g < N; g++) begin
         if (ev_src == IXW'(g)) begin
            nfy_iid = use_cur ? cur_iid_a[g] : cand_iid_a[g];
            nfy_lat = use_cur ? cur_lat_a[g] : cand_lat_a[g];
         end
      end
   end

   for (genvar g = 1; g < N; g++) begin : g_slot
      mdg_group_slot #(
         .N(N), .CW(CW), .LW(LW), .IW(IW), .MEMBER_DECAY(MEMBER_DECAY)
      ) u_slot (
         .clk           (clk),
         .rst_n         (rst_n),
         .tick          (tick),
         .inst_add      (inst_add_v[g]),
         .mem_issue     (mem_issue_v[g]),
         .mem_done      (mem_done_v[g]),
         .pred_add      (pred_add_v[g]),
         .pred_issue    (pred_issue_v[g]),
         .pred_done     (pred_done_v[g]),
         .succ_set      (set_m[g]),
         .in_iid        (ev_iid),
         .in_lat        (ev_lat),
         .nfy_iid       (nfy_iid),
         .nfy_lat       (nfy_lat),
         .st_waiting    (w_a[g]),
         .st_pending    (p_a[g]),
         .st_ready      (r_a[g]),
         .st_executing  (x_a[g]),
         .st_executed   (d_a[g]),
         .succ_row      (rows_a[g]),
         .inst_full     (full_a[g]),
         .has_succ      (hsucc_a[g]),
         .unissued      (unis_a[g]),
         .exec_ok       (xok_a[g]),
         .issue_starts  (starts_a[g]),
         .exec_finishes (fin_a[g]),
         .cand_iid      (cand_iid_a[g]),
         .cand_lat      (cand_lat_a[g]),
         .cur_iid       (cur_iid_a[g]),
         .cur_lat       (cur_lat_a[g]),
         .pred_iid      (pred_iid_a[g]),
         .pred_lat      (pred_lat_a[g])
      );
   end

   // index 0 is reserved: its status bits are tied low
   assign st_waiting   = {w_a, 1'b0};
   assign st_pending   = {p_a, 1'b0};
   assign st_ready     = {r_a, 1'b0};
   assign st_executing = {x_a, 1'b0};
   assign st_executed  = {d_a, 1'b0};

   always_comb begin
      q_crit_iid = '0;
      q_crit_lat = '0;
      for (int g = 1; g < N; g++) begin
         if (q_grp == IXW'(g)) begin
            q_crit_iid = pred_iid_a[g];
            q_crit_lat = pred_lat_a[g];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err <= 1'b0;
      else if (illegal) err <= 1'b1;
   end

endmodule

// File: rtl/mdg_tracker_chk.sv
module mdg_tracker_chk #(
   parameter int N  = 16,
   parameter int LW = 8,
   localparam int IXW = $clog2(N)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           ev_valid,
   input logic           tick,
   input logic [IXW-1:0] q_grp,
   input logic [N-1:0]   st_waiting,
   input logic [N-1:0]   st_pending,
   input logic [N-1:0]   st_ready,
   input logic [N-1:0]   st_executing,
   input logic [N-1:0]   st_executed,
   input logic [LW-1:0]  q_crit_lat,
   input logic           err
);

   // R1: reserved index never reports any status
   assert_idx0_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_waiting[0] || st_pending[0] || st_ready[0] || st_executing[0] || st_executed[0]));

   for (genvar g = 1; g < N; g++) begin : g_grp
      // R2: predecessor phases are mutually exclusive and exhaustive
      assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
         $countones({st_waiting[g], st_pending[g], st_ready[g]}) == 1);
      // R3: a group cannot be both executing and executed
      assert_exec_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
         st_executing[g] |-> !st_executed[g]);
   end

   // R9: error flag is sticky
   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R9: the first illegal event leaves every status vector untouched
   assert_ill_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> ($stable(st_waiting) && $stable(st_pending) && $stable(st_ready)
                      && $stable(st_executing) && $stable(st_executed)));

   // R8: a tick with no event lowers a waiting group's nonzero latency by one
   assert_tick_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ev_valid && st_waiting[q_grp] && (q_crit_lat != '0))
      |=> ((q_grp != $past(q_grp)) || (q_crit_lat == $past(q_crit_lat) - LW'(1))));

endmodule

bind mdg_tracker mdg_tracker_chk #(.N(N), .LW(LW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ev_valid     (ev_valid),
   .tick         (tick),
   .q_grp        (q_grp),
   .st_waiting   (st_waiting),
   .st_pending   (st_pending),
   .st_ready     (st_ready),
   .st_executing (st_executing),
   .st_executed  (st_executed),
   .q_crit_lat   (q_crit_lat),
   .err          (err)
);

// File: tb/test_mdg_tracker.sv
`timescale 1ns/1ps
module test_mdg_tracker;

   localparam int N   = 8;
   localparam int CW  = 3;
   localparam int LW  = 4;
   localparam int IW  = 6;
   localparam int IXW = 3;

   localparam logic [1:0] K_ADD  = 2'd0;
   localparam logic [1:0] K_EDGE = 2'd1;
   localparam logic [1:0] K_ISS  = 2'd2;
   localparam logic [1:0] K_EXE  = 2'd3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ev_valid = 1'b0;
   logic [1:0]     ev_kind = '0;
   logic [IXW-1:0] ev_src = '0;
   logic [IXW-1:0] ev_dst = '0;
   logic [IW-1:0]  ev_iid = '0;
   logic [LW-1:0]  ev_lat = '0;
   logic           tick = 1'b0;
   logic [IXW-1:0] q_grp = '0;
   logic [N-1:0]   st_waiting, st_pending, st_ready, st_executing, st_executed;
   logic [IW-1:0]  q_crit_iid;
   logic [LW-1:0]  q_crit_lat;
   logic           err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   mdg_tracker #(.N(N), .CW(CW), .LW(LW), .IW(IW)) i_mdg_tracker (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
      .ev_src(ev_src), .ev_dst(ev_dst), .ev_iid(ev_iid), .ev_lat(ev_lat),
      .tick(tick), .q_grp(q_grp), .st_waiting(st_waiting), .st_pending(st_pending),
      .st_ready(st_ready), .st_executing(st_executing), .st_executed(st_executed),
      .q_crit_iid(q_crit_iid), .q_crit_lat(q_crit_lat), .err(err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      ev_valid = 1'b0;
      tick = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic ev(input logic [1:0] k, input int s, input int d, input int iid, input int lat);
      ev_kind  = k;
      ev_src   = IXW'(s);
      ev_dst   = IXW'(d);
      ev_iid   = IW'(iid);
      ev_lat   = LW'(lat);
      ev_valid = 1'b1;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   task automatic ticks(input int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 ready", int'(st_ready), 8'hFE);
      chk("R1 executed", int'(st_executed), 8'hFE);
      chk("R1 waiting", int'(st_waiting), 0);
      chk("R1 pending", int'(st_pending), 0);
      chk("R1 executing", int'(st_executing), 0);
      chk("R1 err", int'(err), 0);
      q_grp = 3'd3;
      #1;
      chk("R1 R10 query lat", int'(q_crit_lat), 0);
      chk("R1 R10 query iid", int'(q_crit_iid), 0);
   endtask

   task automatic t_chain();
      do_reset();
      ev(K_ADD, 1, 0, 0, 0);
      ev(K_ADD, 1, 0, 0, 0);
      ev(K_EDGE, 1, 2, 0, 0);
      ev(K_ADD, 2, 0, 0, 0);
      chk("R2 succ waiting", int'(st_waiting[2]), 1);
      chk("R2 src ready", int'(st_ready[1]), 1);
      chk("R3 src not executed", int'(st_executed[1]), 0);
      ev(K_ISS, 1, 0, 5, 3);
      chk("R3 partial issue not executing", int'(st_executing[1]), 0);
      chk("R5 succ still waiting", int'(st_waiting[2]), 1);
      ev(K_ISS, 1, 0, 6, 7);
      chk("R3 all issued executing", int'(st_executing[1]), 1);
      chk("R5 succ pending", int'(st_pending[2]), 1);
      q_grp = 3'd2;
      #1;
      chk("R5 R10 crit iid", int'(q_crit_iid), 6);
      chk("R5 R10 crit lat", int'(q_crit_lat), 7);
      ev(K_EXE, 1, 0, 0, 0);
      chk("R6 half done still pending", int'(st_pending[2]), 1);
      chk("R3 half done still executing", int'(st_executing[1]), 1);
      ev(K_EXE, 1, 0, 0, 0);
      chk("R3 executed", int'(st_executed[1]), 1);
      chk("R6 succ ready", int'(st_ready[2]), 1);
      chk("R9 no error on legal flow", int'(err), 0);
   endtask

   task automatic t_live_edge();
      do_reset();
      ev(K_ADD, 3, 0, 0, 0);
      ev(K_ADD, 3, 0, 0, 0);
      ev(K_ISS, 3, 0, 1, 5);
      ev(K_ISS, 3, 0, 2, 3);
      ev(K_EDGE, 3, 4, 0, 0);
      chk("R7 edge from executing -> pending", int'(st_pending[4]), 1);
      q_grp = 3'd4;
      #1;
      chk("R4 R7 smaller lat not critical iid", int'(q_crit_iid), 1);
      chk("R4 R7 critical lat", int'(q_crit_lat), 5);
      do_reset();
      ev(K_ADD, 5, 0, 0, 0);
      ev(K_ISS, 5, 0, 9, 6);
      ticks(2);
      ev(K_EDGE, 5, 6, 0, 0);
      q_grp = 3'd6;
      #1;
      chk("R4 member latency aged", int'(q_crit_lat), 4);
      chk("R4 member iid", int'(q_crit_iid), 9);
   endtask

   task automatic t_tick();
      do_reset();
      ev(K_ADD, 1, 0, 0, 0);
      ev(K_ADD, 2, 0, 0, 0);
      ev(K_EDGE, 1, 3, 0, 0);
      ev(K_EDGE, 2, 3, 0, 0);
      ev(K_ISS, 1, 0, 11, 4);
      q_grp = 3'd3;
      #1;
      chk("R2 one of two executing -> waiting", int'(st_waiting[3]), 1);
      chk("R5 crit lat", int'(q_crit_lat), 4);
      ticks(2);
      chk("R8 waiting counts down", int'(q_crit_lat), 2);
      ev(K_ISS, 2, 0, 12, 6);
      chk("R2 both executing -> pending", int'(st_pending[3]), 1);
      chk("R5 larger replaces iid", int'(q_crit_iid), 12);
      chk("R5 larger replaces lat", int'(q_crit_lat), 6);
      ticks(3);
      chk("R8 pending holds", int'(q_crit_lat), 6);
      do_reset();
      ev(K_ADD, 1, 0, 0, 0);
      ev(K_ADD, 2, 0, 0, 0);
      ev(K_EDGE, 1, 3, 0, 0);
      ev(K_EDGE, 2, 3, 0, 0);
      ev(K_ISS, 1, 0, 7, 2);
      ticks(4);
      q_grp = 3'd3;
      #1;
      chk("R8 stops at zero", int'(q_crit_lat), 0);
      chk("R8 still waiting", int'(st_waiting[3]), 1);
   endtask

   task automatic t_errors();
      do_reset();
      ev(K_ADD, 0, 0, 0, 0);
      chk("R9 group 0 err", int'(err), 1);
      chk("R9 group 0 no change", int'(st_ready), 8'hFE);
      ev(K_ADD, 1, 0, 0, 0);
      chk("R9 err sticky", int'(err), 1);

      do_reset();
      ev(K_ADD, 1, 0, 0, 0);
      ev(K_EDGE, 1, 2, 0, 0);
      ev(K_ADD, 1, 0, 0, 0);
      chk("R9 add after successor err", int'(err), 1);
      ev(K_ISS, 1, 0, 1, 1);
      ev(K_EXE, 1, 0, 0, 0);
      chk("R9 member not added", int'(st_executed[1]), 1);

      do_reset();
      ev(K_EDGE, 1, 2, 0, 0);
      chk("R9 edge from executed err", int'(err), 1);
      chk("R9 edge not added", int'(st_ready[2]), 1);

      do_reset();
      ev(K_ADD, 1, 0, 0, 0);
      ev(K_EDGE, 1, 2, 0, 0);
      ev(K_EDGE, 1, 2, 0, 0);
      chk("R9 duplicate edge err", int'(err), 1);
      ev(K_ISS, 1, 0, 1, 1);
      ev(K_EXE, 1, 0, 0, 0);
      chk("R9 duplicate not counted", int'(st_ready[2]), 1);

      do_reset();
      ev(K_ADD, 1, 0, 0, 0);
      ev(K_EDGE, 1, 2, 0, 0);
      ev(K_ADD, 2, 0, 0, 0);
      ev(K_ISS, 2, 0, 3, 3);
      ev(K_EXE, 2, 0, 0, 0);
      chk("R9 finish while not ready err", int'(err), 1);
      chk("R9 finish ignored", int'(st_executed[2]), 0);

      do_reset();
      ev(K_ADD, 4, 0, 0, 0);
      ev(K_ISS, 4, 0, 1, 1);
      ev(K_ISS, 4, 0, 2, 2);
      chk("R9 issue without member err", int'(err), 1);
      ev(K_EXE, 4, 0, 0, 0);
      chk("R9 extra issue ignored", int'(st_executed[4]), 1);

      do_reset();
      ev(K_ADD, 4, 0, 0, 0);
      ev(K_EDGE, 4, 4, 0, 0);
      chk("R9 self edge err", int'(err), 1);
      ev(K_EDGE, 4, 0, 0, 0);
      chk("R9 edge to 0 leaves 4 without successor", int'(st_executed[4]), 0);
   endtask

   task automatic t_overflow();
      do_reset();
      for (int i = 0; i < 7; i++) ev(K_ADD, 1, 0, 0, 0);
      chk("R9 seven members legal", int'(err), 0);
      ev(K_ADD, 1, 0, 0, 0);
      chk("R9 counter full err", int'(err), 1);
      for (int i = 0; i < 6; i++) ev(K_ISS, 1, 0, i, 1);
      chk("R3 six of seven not executing", int'(st_executing[1]), 0);
      ev(K_ISS, 1, 0, 6, 1);
      chk("R3 seven of seven executing", int'(st_executing[1]), 1);
      for (int i = 0; i < 7; i++) ev(K_EXE, 1, 0, 0, 0);
      chk("R3 R9 executed after seven", int'(st_executed[1]), 1);
   endtask

   initial begin
      t_reset();
      t_chain();
      t_live_edge();
      t_tick();
      t_errors();
      t_overflow();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule